// File: doc/BRIEF.md
# Dual-Counter Frequency Measurement Unit

This block measures the rate of one tick stream against another. Two 16-bit up-counters share a gated measuring window. The reference counter, counter 2, counts reference ticks. The window closes once that counter has taken a programmed number of ticks, 2^(2k+1) for a 3-bit window code k. While the window is open, counter 1 counts ticks of the measured source. Firmware reads the frozen counter 1 value and scales it by the window length to get the unknown frequency.

The measured source is picked by a one-hot select from several tick inputs. One of those inputs, chosen by a parameter, goes through a divide-by-256 prescaler so that a fast oscillator fits in the counter. An active-low swap control can exchange the two sources between the counters. Counter 2 then times the window from the measured source and counter 1 counts reference ticks.

A preset control loads both counters with all ones. A clear control holds counter 1 at zero and drops the overflow flag. A select bit puts either counter on a byte-split readback pair. All tick inputs are clock enables that are already synchronous to `clk`.

Top module: `fm_freq_meas`

## Requirements
- R1: After reset both counters read 0000h, `ovf` is 0 and `done` is 0.
- R2: With enable held, the window ends on the counter-2 tick that brings the run's counter-2 tick total to 2^(2k+1), where k is `tap`. The values are 2 for k=0, 8, 32, 128, 512, 2048, 8192 and 32768 for k=7.
- R3: Counter 1 adds one for each counter-1 tick inside the window, including a tick in the window's last cycle. Both counters then hold until enable is lowered.
- R4: With `swap_n`=1 the measured source drives counter 1 and `ref_tick` drives counter 2. With `swap_n`=0 they are exchanged.
- R5: While `set_all` is 1, both counters become FFFFh and stay there, and no counting happens. Counter 1 is the exception when `clr1` is also 1.
- R6: While `clr1` is 1, counter 1 becomes 0000h and `ovf` becomes 0. Clear takes priority over preset for counter 1.
- R7: While `cnt_en` is 0, neither counter moves on ticks and the window tally restarts. Raising `cnt_en` again starts a fresh window.
- R8: `rd_sel`=0 shows counter 1 and `rd_sel`=1 shows counter 2. The counter's bits 7:0 appear on `rd_lo` and bits 15:8 on `rd_hi`.
- R9: A counter-1 increment from FFFFh to 0000h sets `ovf`. The flag stays set until `clr1`.
- R10: Bit i of `meas_sel` selects `src_tick[i]`. Input 1 is divided by 256, so its 256th tick after selection yields the first count. An all-zero select counts nothing.
- R11: `done` is high for exactly one cycle after the window closes. It does not return until enable is cycled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick | input | 3 | Candidate measured-source tick enables |
| meas_sel | input | 3 | One-hot measured-source select |
| ref_tick | input | 1 | Reference tick enable |
| swap_n | input | 1 | 0 exchanges sources between counters |
| cnt_en | input | 1 | Counting enable |
| set_all | input | 1 | Preset both counters to all ones |
| clr1 | input | 1 | Hold counter 1 at zero, clear overflow |
| rd_sel | input | 1 | Readback select: 0 counter 1, 1 counter 2 |
| tap | input | 3 | Window length code k |
| rd_lo | output | 8 | Selected counter bits 7:0 |
| rd_hi | output | 8 | Selected counter bits 15:8 |
| ovf | output | 1 | Sticky counter-1 wrap flag |
| done | output | 1 | One-cycle window-complete pulse |

## Verification
A wrong window tally shows up as a `done` pulse that comes early or late. It also shows as a counter 1 value that keeps moving after the pulse, on the first cycle after the miscounted tick. A prescaler or select fault changes the counter 1 readback within one cycle of the 256th prescaled tick, or of the first tick from a wrongly chosen input. Swap, preset and clear faults show on the readback pair in the cycle after the control changes. The bench compares the readback, `done` and `ovf` against a model on every cycle, so any divergence is seen at once.

// File: rtl/fm_pkg.sv
package fm_pkg;
   // number of window ticks for a tap code: 2^(2k+1)
   function automatic longint unsigned fm_stop_count(input int unsigned k);
      return longint'(1) << (2 * k + 1);
   endfunction

   // tally width able to hold the longest window for a tap width
   function automatic int unsigned fm_win_width(input int unsigned tap_w);
      return 2 * ((1 << tap_w) - 1) + 2;
   endfunction
endpackage

// File: rtl/fm_prescale.sv
module fm_prescale #(
   parameter int PRE_W = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic tick_in,
   output logic tick_out
);
   logic [PRE_W-1:0] div_q;

   assign tick_out = active & tick_in & (&div_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        div_q <= '0;
      else if (!active)  div_q <= '0;
      else if (tick_in)  div_q <= div_q + 1'b1;
   end

   p_div_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (active && tick_in && (&div_q)) |=> (div_q == '0));
endmodule

// File: rtl/fm_src_mux.sv
module fm_src_mux #(
   parameter int NSRC    = 3,
   parameter int PRE_IDX = 1,
   parameter int PRE_W   = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] src_tick,
   input  logic [NSRC-1:0] meas_sel,
   output logic            meas_tick
);
   logic [NSRC-1:0] eff_tick;

   generate
      for (genvar gi = 0; gi < NSRC; gi++) begin : g_src
         if (gi == PRE_IDX) begin : g_div
            fm_prescale #(.PRE_W(PRE_W)) u_pre (
               .clk     (clk),
               .rst_n   (rst_n),
               .active  (meas_sel[gi]),
               .tick_in (src_tick[gi]),
               .tick_out(eff_tick[gi])
            );
         end else begin : g_direct
            assign eff_tick[gi] = src_tick[gi] & meas_sel[gi];
         end
      end
   endgenerate

   assign meas_tick = |eff_tick;

   p_sel_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(meas_sel));
endmodule

// File: rtl/fm_counter.sv
module fm_counter #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          set,
   input  logic          inc,
   output logic [CW-1:0] q,
   output logic          wrap
);
   assign wrap = inc & ~clr & ~set & (&q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (clr)  q <= '0;
      else if (set)  q <= '1;
      else if (inc)  q <= q + 1'b1;
   end

   p_clear_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (q == '0));
   p_preset_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (set && !clr) |=> (&q));
   p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc && !clr && !set) |=> $stable(q));
endmodule

// File: rtl/fm_window.sv
module fm_window
   import fm_pkg::*;
#(
   parameter int TAP_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             set_all,
   input  logic             tick,
   input  logic [TAP_W-1:0] tap,
   output logic             run,
   output logic             done
);
   localparam int WIN_W = fm_win_width(TAP_W);

   logic [WIN_W-1:0] tally;
   logic [WIN_W-1:0] last_val;
   logic             halted;
   logic             hit;

   assign last_val = WIN_W'(fm_stop_count(int'(tap)) - 1);
   assign run      = en & ~halted & ~set_all;
   assign hit      = run & tick & (tally == last_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tally  <= '0;
         halted <= 1'b0;
         done   <= 1'b0;
      end else begin
         done <= hit;
         if (!en) begin
            tally  <= '0;
            halted <= 1'b0;
         end else begin
            if (run && tick) tally <= tally + 1'b1;
            if (hit)         halted <= 1'b1;
         end
      end
   end

   p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_halt_after_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (done && en) |-> !run);
endmodule

// File: rtl/fm_freq_meas.sv
module fm_freq_meas
   import fm_pkg::*;
#(
   parameter int CW      = 16,
   parameter int TAP_W   = 3,
   parameter int NSRC    = 3,
   parameter int PRE_IDX = 1,
   parameter int PRE_W   = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] src_tick,
   input  logic [NSRC-1:0] meas_sel,
   input  logic            ref_tick,
   input  logic            swap_n,
   input  logic            cnt_en,
   input  logic            set_all,
   input  logic            clr1,
   input  logic            rd_sel,
   input  logic [TAP_W-1:0] tap,
   output logic [CW/2-1:0] rd_lo,
   output logic [CW/2-1:0] rd_hi,
   output logic            ovf,
   output logic            done
);
   localparam int HW = CW / 2;

   generate
      if (CW % 2 != 0 || CW < 2) begin : g_bad_cw
         $error("fm_freq_meas: CW must be even and at least 2");
      end
      if (PRE_IDX < 0 || PRE_IDX >= NSRC) begin : g_bad_idx
         $error("fm_freq_meas: PRE_IDX outside source range");
      end
      if (TAP_W < 1 || TAP_W > 4) begin : g_bad_tap
         $error("fm_freq_meas: TAP_W must be 1..4");
      end
   endgenerate

   logic          meas_tick, tick1, tick2, run;
   logic [CW-1:0] c1_q, c2_q, rd_word;
   logic          wrap1, wrap2;

   fm_src_mux #(.NSRC(NSRC), .PRE_IDX(PRE_IDX), .PRE_W(PRE_W)) u_mux (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_tick (src_tick),
      .meas_sel (meas_sel),
      .meas_tick(meas_tick)
   );

   assign tick1 = swap_n ? meas_tick : ref_tick;
   assign tick2 = swap_n ? ref_tick  : meas_tick;

   fm_window #(.TAP_W(TAP_W)) u_win (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (cnt_en),
      .set_all(set_all),
      .tick   (tick2),
      .tap    (tap),
      .run    (run),
      .done   (done)
   );

   fm_counter #(.CW(CW)) u_c1 (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (clr1),
      .set  (set_all),
      .inc  (run & tick1),
      .q    (c1_q),
      .wrap (wrap1)
   );

   fm_counter #(.CW(CW)) u_c2 (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (1'b0),
      .set  (set_all),
      .inc  (run & tick2),
      .q    (c2_q),
      .wrap (wrap2)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ovf <= 1'b0;
      else if (clr1)  ovf <= 1'b0;
      else if (wrap1) ovf <= 1'b1;
   end

   assign rd_word = rd_sel ? c2_q : c1_q;
   assign rd_lo   = rd_word[HW-1:0];
   assign rd_hi   = rd_word[CW-1:HW];

   p_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !clr1 && !set_all) |=> $stable(c1_q));
   p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !clr1) |=> ovf);
   p_ovf_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      clr1 |=> !ovf);
   p_wrap_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wrap1 |=> ovf);
   p_c2_wrap_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wrap2 |=> (c2_q == '0));
endmodule

// File: tb/fm_freq_meas_bench.sv
module fm_freq_meas_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] src_tick = '0, meas_sel = '0, tap = '0;
   logic       ref_tick = 0, swap_n = 1, cnt_en = 0, set_all = 0, clr1 = 0, rd_sel = 0;
   logic [7:0] rd_lo, rd_hi;
   logic       ovf, done;

   int total = 0, bad = 0;
   bit finished = 0;

   // reference state
   int unsigned m_c1, m_c2, m_win, m_pre;
   bit m_halt, m_ovf, m_done;

   always #4 clk = ~clk;

   fm_freq_meas u_fm_freq_meas (
      .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .meas_sel(meas_sel),
      .ref_tick(ref_tick), .swap_n(swap_n), .cnt_en(cnt_en), .set_all(set_all),
      .clr1(clr1), .rd_sel(rd_sel), .tap(tap), .rd_lo(rd_lo), .rd_hi(rd_hi),
      .ovf(ovf), .done(done)
   );

   function automatic int unsigned stop_of(input int unsigned k);
      return 32'd1 << (2 * k + 1);
   endfunction

   task automatic check(input string tag, input string what,
                        input int unsigned act, input int unsigned exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic model_step();
      bit pre_fire, meas, t1, t2, run, hit;
      pre_fire = 0;
      if (!meas_sel[1]) m_pre = 0;
      else if (src_tick[1]) begin
         pre_fire = (m_pre == 255);
         m_pre = (m_pre + 1) % 256;
      end
      meas = (meas_sel[0] & src_tick[0]) | (meas_sel[2] & src_tick[2]) | pre_fire;
      t1 = swap_n ? meas : ref_tick;
      t2 = swap_n ? ref_tick : meas;
      run = cnt_en & !m_halt & !set_all;
      hit = run & t2 & (m_win == stop_of(tap) - 1);
      if (clr1) begin m_c1 = 0; m_ovf = 0; end
      else if (set_all) m_c1 = 16'hFFFF;
      else if (run && t1) begin
         if (m_c1 == 16'hFFFF) m_ovf = 1;
         m_c1 = (m_c1 + 1) & 16'hFFFF;
      end
      if (set_all) m_c2 = 16'hFFFF;
      else if (run && t2) m_c2 = (m_c2 + 1) & 16'hFFFF;
      if (!cnt_en) begin m_win = 0; m_halt = 0; end
      else begin
         if (run && t2) m_win++;
         if (hit) m_halt = 1;
      end
      m_done = hit;
   endtask

   task automatic cycle(input string tag);
      model_step();
      @(posedge clk);
      @(negedge clk);
      check(tag, "readback", {rd_hi, rd_lo}, rd_sel ? m_c2 : m_c1);
      check(tag, "done", done, m_done);
      check(tag, "ovf", ovf, m_ovf);
   endtask

   task automatic run_rand(input string tag, input int n, input int p_ref, input int p_src);
      for (int i = 0; i < n; i++) begin
         ref_tick = ($urandom % 100) < p_ref;
         for (int j = 0; j < 3; j++) src_tick[j] = ($urandom % 100) < p_src;
         cycle(tag);
      end
   endtask

   task automatic restart_en();
      cnt_en = 0; cycle("R7"); cnt_en = 1;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         bad++; total++;
         $display("FAIL watchdog R0 actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int unsigned seed_r;
      seed_r = $urandom(32'h5eed);
      m_c1 = 0; m_c2 = 0; m_win = 0; m_pre = 0; m_halt = 0; m_ovf = 0; m_done = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state on both readback choices
      check("R1", "c1", {rd_hi, rd_lo}, 0);
      rd_sel = 1; #1 check("R1", "c2", {rd_hi, rd_lo}, 0);
      check("R1", "done", done, 0); check("R1", "ovf", ovf, 0);

      // R5 preset, R6 clear and its priority
      set_all = 1; cycle("R5"); rd_sel = 0; cycle("R5");
      clr1 = 1; cycle("R6"); rd_sel = 1; cycle("R6");
      set_all = 0; clr1 = 0; cycle("R6");

      // R2 every window length, source 0 measured; ref every cycle for k=7
      meas_sel = 3'b001; swap_n = 1;
      for (int k = 0; k < 8; k++) begin
         tap = 3'(k); clr1 = 1; cycle("R2"); clr1 = 0;
         restart_en();
         rd_sel = k[0];
         run_rand("R2", int'(stop_of(k)) + 20, (k == 7) ? 100 : 60, 40);
      end

      // R3 freeze after done with ticks still arriving
      tap = 3'd2; rd_sel = 0; restart_en();
      run_rand("R3", 120, 70, 80);

      // R4 swap: measured source times the window
      swap_n = 0; tap = 3'd2; restart_en();
      run_rand("R4", 150, 50, 60);
      rd_sel = 1; run_rand("R4", 20, 50, 60);
      swap_n = 1;

      // R7 enable dropped mid-run, ticks ignored, fresh window on re-enable
      tap = 3'd4; rd_sel = 0; restart_en();
      run_rand("R7", 100, 60, 60);
      cnt_en = 0; run_rand("R7", 50, 90, 90);
      cnt_en = 1; run_rand("R7", 700, 90, 50);

      // R9 overflow: preset then first measured tick wraps counter 1
      tap = 3'd6; cnt_en = 0; set_all = 1; cycle("R9"); set_all = 0; cnt_en = 1;
      run_rand("R9", 40, 50, 70);
      run_rand("R9", 10, 0, 0);
      clr1 = 1; cycle("R6"); clr1 = 0; cycle("R6");

      // R10 prescaled source and empty select
      meas_sel = 3'b010; tap = 3'd5; restart_en();
      run_rand("R10", 900, 100, 100);
      meas_sel = 3'b000; restart_en();
      run_rand("R10", 60, 100, 100);
      meas_sel = 3'b100; tap = 3'd1; restart_en();
      run_rand("R11", 60, 50, 50);

      // R8 and mixed random controls
      for (int i = 0; i < 3000; i++) begin
         rd_sel   = $urandom % 2;
         if ($urandom % 50 == 0) cnt_en  = ~cnt_en;
         set_all  = ($urandom % 80) == 0;
         clr1     = ($urandom % 80) == 0;
         if ($urandom % 40 == 0) swap_n = ~swap_n;
         if ($urandom % 100 == 0) tap = 3'($urandom % 4);
         if ($urandom % 200 == 0) meas_sel = 3'(1 << ($urandom % 3));
         ref_tick = $urandom % 2;
         src_tick = 3'($urandom);
         cycle("R8");
      end

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule